// File: doc/BRIEF.md
# Indexed Byte Memory Port with Window Locks

This block places a byte-wide memory behind a three-register host port. The host loads a 16-bit pointer one byte at a time: port offset 0 replaces the low byte and offset 1 replaces the high byte. It then moves data through offset 3. A data write stores the byte at the pointed location and always sets the pointer back to zero. A data read returns the byte at the pointed location and leaves the pointer unchanged. Offset 2 does nothing.

Two fixed 16-byte windows near the bottom of the space can each be fenced off by a lock bit. A sideband strobe flips one chosen lock bit. While a window is locked, reads of it return all ones and writes to it are dropped. Locations at or above the memory size are treated the same way. The storage is a synchronous RAM, so read data appears one cycle after the read strobe. Reset clears the pointer and the locks but leaves the stored bytes alone.

Top module: `nvram_index_port`

## Requirements
- R1: A port write at offset 0 replaces bits 7:0 of the pointer, and one at offset 1 replaces bits 15:8. The other byte is kept in both cases.
- R2: A port write at offset 3 stores the data byte at the location the pointer selects, when that location is reachable.
- R3: After any port write at offset 3, the pointer is 0x0000, whether or not the byte was stored.
- R4: A port read at offset 3 presents the selected byte on the read-data output in the cycle after the strobe and does not change the pointer. The output holds its value until the next read strobe.
- R5: A port read at offset 0, 1 or 2 presents 0xFF.
- R6: A port write at offset 2 changes neither the pointer nor the memory.
- R7: While lock bit 0 is set, locations 0x20 to 0x2F read as 0xFF and ignore writes.
- R8: While lock bit 1 is set, locations 0x30 to 0x3F read as 0xFF and ignore writes.
- R9: A toggle strobe inverts the lock bit that the lock-select input names (0 or 1). The other lock bit is kept.
- R10: Locations at or above MEM_BYTES read as 0xFF. Writes to them change no stored byte, including the byte whose low address bits they share.
- R11: Reset clears the pointer and both lock bits and sets the read-data output to 0xFF. Memory contents survive reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| portWr | input | 1 | Host write strobe, one cycle |
| portRd | input | 1 | Host read strobe, one cycle |
| portOff | input | 2 | Port offset of the access |
| portWdata | input | 8 | Host write data |
| portRdata | output | 8 | Read data, valid the cycle after portRd |
| lockToggle | input | 1 | Strobe that flips one lock bit |
| lockSel | input | 1 | Which lock bit lockToggle flips |

## Verification
The checker assumes that the host never raises the read and write strobes in the same cycle. Every check on read data assumes that a strobe's effect is judged against the pointer and lock state it saw, before any toggle in that same cycle takes effect. The bench drives each strobe for exactly one cycle from its own task and issues accesses one at a time. It never combines a lock toggle with a data access in the same cycle, so the stimulus stays inside these assumptions.

// File: rtl/nvram_index_port_pkg.sv
package nvram_index_port_pkg;
  localparam int NVP_LOCKS = 2;
  localparam int NVP_SEL_W = (NVP_LOCKS > 1) ? $clog2(NVP_LOCKS) : 1;
  localparam int NVP_IDX_W = 16;
  localparam int NVP_DAT_W = 8;

  localparam logic [1:0] OFF_IDX_LO = 2'd0;
  localparam logic [1:0] OFF_IDX_HI = 2'd1;
  localparam logic [1:0] OFF_DATA   = 2'd3;

  typedef struct packed {
    logic                 loadLo;
    logic                 loadHi;
    logic                 ramWe;
    logic                 idxClr;
    logic                 rdCapture;
    logic                 rdHit;
    logic [NVP_LOCKS-1:0] lockFlip;
  } nvp_ctrl_t;
endpackage

// File: rtl/nvram_index_port_ctrl.sv
module nvram_index_port_ctrl
  import nvram_index_port_pkg::*;
#(
  parameter int MEM_BYTES = 1024,
  parameter int LOCK_BASE = 32,
  parameter int WIN_BYTES = 16
) (
  input  logic                 portWr,
  input  logic                 portRd,
  input  logic [1:0]           portOff,
  input  logic                 lockToggle,
  input  logic [NVP_SEL_W-1:0] lockSel,
  input  logic [NVP_IDX_W-1:0] idxVal,
  input  logic [NVP_LOCKS-1:0] lockVal,
  output nvp_ctrl_t            ctrl
);
  localparam logic [NVP_IDX_W:0] MEM_LIM = MEM_BYTES[NVP_IDX_W:0];

  logic [NVP_IDX_W:0]   idxWide;
  logic [NVP_LOCKS-1:0] winHit;
  logic                 inRange;
  logic                 blocked;
  logic                 reachable;
  logic                 dataOff;

  assign idxWide = {1'b0, idxVal};

  for (genvar n = 0; n < NVP_LOCKS; n++) begin : g_win
    localparam int LO_I = LOCK_BASE + n * WIN_BYTES;
    localparam int HI_I = LOCK_BASE + (n + 1) * WIN_BYTES;
    localparam logic [NVP_IDX_W:0] WIN_LO = LO_I[NVP_IDX_W:0];
    localparam logic [NVP_IDX_W:0] WIN_HI = HI_I[NVP_IDX_W:0];
    assign winHit[n] = (idxWide >= WIN_LO) && (idxWide < WIN_HI);
  end

  for (genvar n = 0; n < NVP_LOCKS; n++) begin : g_flip
    assign ctrl.lockFlip[n] = lockToggle && (lockSel == n[NVP_SEL_W-1:0]);
  end

  always_comb begin
    inRange   = idxWide < MEM_LIM;
    blocked   = |(winHit & lockVal);
    reachable = inRange && !blocked;
    dataOff   = portOff == OFF_DATA;
  end

  always_comb begin
    ctrl.loadLo    = portWr && (portOff == OFF_IDX_LO);
    ctrl.loadHi    = portWr && (portOff == OFF_IDX_HI);
    ctrl.idxClr    = portWr && dataOff;
    ctrl.ramWe     = portWr && dataOff && reachable;
    ctrl.rdCapture = portRd;
    ctrl.rdHit     = portRd && dataOff && reachable;
  end
endmodule

// File: rtl/nvram_index_port_dp.sv
module nvram_index_port_dp
  import nvram_index_port_pkg::*;
#(
  parameter int MEM_BYTES = 1024
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  nvp_ctrl_t            ctrl,
  input  logic [NVP_DAT_W-1:0] wrData,
  output logic [NVP_IDX_W-1:0] idxVal,
  output logic [NVP_LOCKS-1:0] lockVal,
  output logic [NVP_DAT_W-1:0] rdData
);
  localparam int AW = (MEM_BYTES > 1) ? $clog2(MEM_BYTES) : 1;
  localparam int HB = NVP_IDX_W / 2;

  logic [NVP_DAT_W-1:0] mem [MEM_BYTES];
  logic [NVP_DAT_W-1:0] ramQ;
  logic                 onesQ;
  logic [AW-1:0]        ramAddr;

  assign ramAddr = idxVal[AW-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idxVal <= '0;
    end else if (ctrl.idxClr) begin
      idxVal <= '0;
    end else begin
      if (ctrl.loadLo) idxVal[HB-1:0] <= wrData[HB-1:0];
      if (ctrl.loadHi) idxVal[NVP_IDX_W-1:HB] <= wrData[HB-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) lockVal <= '0;
    else       lockVal <= lockVal ^ ctrl.lockFlip;
  end

  always_ff @(posedge clk) begin
    if (ctrl.ramWe) mem[ramAddr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (ctrl.rdHit) ramQ <= mem[ramAddr];
  end

  always_ff @(posedge clk) begin
    if (!rstN)               onesQ <= 1'b1;
    else if (ctrl.rdCapture) onesQ <= !ctrl.rdHit;
  end

  assign rdData = onesQ ? '1 : ramQ;
endmodule

// File: rtl/nvram_index_port.sv
module nvram_index_port
  import nvram_index_port_pkg::*;
#(
  parameter int MEM_BYTES = 1024,
  parameter int LOCK_BASE = 32,
  parameter int WIN_BYTES = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       portWr,
  input  logic       portRd,
  input  logic [1:0] portOff,
  input  logic [7:0] portWdata,
  output logic [7:0] portRdata,
  input  logic       lockToggle,
  input  logic       lockSel
);
  nvp_ctrl_t            ctrlW;
  logic [NVP_IDX_W-1:0] idxW;
  logic [NVP_LOCKS-1:0] lockW;

  nvram_index_port_ctrl #(
    .MEM_BYTES(MEM_BYTES), .LOCK_BASE(LOCK_BASE), .WIN_BYTES(WIN_BYTES)
  ) ctrl_i (
    .portWr(portWr), .portRd(portRd), .portOff(portOff),
    .lockToggle(lockToggle), .lockSel(lockSel),
    .idxVal(idxW), .lockVal(lockW), .ctrl(ctrlW)
  );

  nvram_index_port_dp #(.MEM_BYTES(MEM_BYTES)) dp_i (
    .clk(clk), .rstN(rstN), .ctrl(ctrlW), .wrData(portWdata),
    .idxVal(idxW), .lockVal(lockW), .rdData(portRdata)
  );
endmodule

// File: rtl/nvram_index_port_chk.sv
module nvram_index_port_chk #(
  parameter int MEM_BYTES = 1024,
  parameter int LOCK_BASE = 32,
  parameter int WIN_BYTES = 16
) (
  input logic        clk,
  input logic        rstN,
  input logic        portWr,
  input logic        portRd,
  input logic [1:0]  portOff,
  input logic [7:0]  portRdata,
  input logic        lockToggle,
  input logic        lockSel,
  input logic [15:0] idxVal,
  input logic [1:0]  lockVal
);
  localparam int HI0_I = LOCK_BASE + WIN_BYTES;
  localparam logic [16:0] MEM_LIM = MEM_BYTES[16:0];
  localparam logic [16:0] W0_LO   = LOCK_BASE[16:0];
  localparam logic [16:0] W0_HI   = HI0_I[16:0];

  p_no_dual_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !(portWr && portRd));

  p_idx_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
    (portWr && portOff == 2'd3) |=> idxVal == 16'h0000);

  p_rd_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !portRd |=> $stable(portRdata));

  p_rd_other_r5: assert property (@(posedge clk) disable iff (!rstN)
    (portRd && portOff != 2'd3) |=> portRdata == 8'hFF);

  p_off2_idx_r6: assert property (@(posedge clk) disable iff (!rstN)
    (portWr && portOff == 2'd2) |=> $stable(idxVal));

  p_lock0_rd_r7: assert property (@(posedge clk) disable iff (!rstN)
    (portRd && portOff == 2'd3 && lockVal[0] &&
     {1'b0, idxVal} >= W0_LO && {1'b0, idxVal} < W0_HI) |=> portRdata == 8'hFF);

  p_lock_flip_r9: assert property (@(posedge clk) disable iff (!rstN)
    lockToggle |=> lockVal[$past(lockSel)] != $past(lockVal[lockSel]));

  p_lock_keep_r9: assert property (@(posedge clk) disable iff (!rstN)
    !lockToggle |=> $stable(lockVal));

  p_oob_rd_r10: assert property (@(posedge clk) disable iff (!rstN)
    (portRd && portOff == 2'd3 && {1'b0, idxVal} >= MEM_LIM) |=> portRdata == 8'hFF);
endmodule

bind nvram_index_port nvram_index_port_chk #(
  .MEM_BYTES(MEM_BYTES), .LOCK_BASE(LOCK_BASE), .WIN_BYTES(WIN_BYTES)
) chk_i (
  .clk(clk), .rstN(rstN), .portWr(portWr), .portRd(portRd),
  .portOff(portOff), .portRdata(portRdata), .lockToggle(lockToggle),
  .lockSel(lockSel), .idxVal(idxW), .lockVal(lockW)
);

// File: tb/nvram_index_port_tb_top.sv
module nvram_index_port_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       portWr = 1'b0;
  logic       portRd = 1'b0;
  logic [1:0] portOff = 2'd0;
  logic [7:0] portWdata = 8'd0;
  logic [7:0] portRdata;
  logic       lockToggle = 1'b0;
  logic       lockSel = 1'b0;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  nvram_index_port #(.MEM_BYTES(1024)) dut_i (
    .clk(clk), .rstN(rstN), .portWr(portWr), .portRd(portRd),
    .portOff(portOff), .portWdata(portWdata), .portRdata(portRdata),
    .lockToggle(lockToggle), .lockSel(lockSel)
  );

  // {address[31:16], write data[15:8], expected read-back[7:0]}
  localparam logic [31:0] VEC [10] = '{
    {16'h0000, 8'h5A, 8'h5A},
    {16'h0001, 8'hA5, 8'hA5},
    {16'h001F, 8'h11, 8'h11},
    {16'h0020, 8'h22, 8'h22},
    {16'h003F, 8'h33, 8'h33},
    {16'h0040, 8'h44, 8'h44},
    {16'h0123, 8'h77, 8'h77},
    {16'h03FF, 8'hC3, 8'hC3},
    {16'h0400, 8'h99, 8'hFF},
    {16'hFFFF, 8'h12, 8'hFF}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wrPort(input logic [1:0] off, input logic [7:0] d);
    @(negedge clk);
    portWr = 1'b1; portOff = off; portWdata = d;
    @(negedge clk);
    portWr = 1'b0;
  endtask

  task automatic rdPort(input logic [1:0] off, output logic [7:0] d);
    @(negedge clk);
    portRd = 1'b1; portOff = off;
    @(negedge clk);
    portRd = 1'b0;
    d = portRdata;
  endtask

  task automatic flipLock(input logic n);
    @(negedge clk);
    lockToggle = 1'b1; lockSel = n;
    @(negedge clk);
    lockToggle = 1'b0;
  endtask

  task automatic setIdx(input logic [15:0] a);
    wrPort(2'd0, a[7:0]);
    wrPort(2'd1, a[15:8]);
  endtask

  task automatic putByte(input logic [15:0] a, input logic [7:0] d);
    setIdx(a);
    wrPort(2'd3, d);
  endtask

  task automatic getByte(input logic [15:0] a, output logic [7:0] d);
    setIdx(a);
    rdPort(2'd3, d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R11 read data after reset", portRdata, 8'hFF);

    // table walk: R2, R4, R10
    for (int i = 0; i < 10; i++) begin
      putByte(VEC[i][31:16], VEC[i][15:8]);
      getByte(VEC[i][31:16], v);
      check("R2/R4/R10 table read-back", v, VEC[i][7:0]);
    end
    getByte(16'h0000, v);
    check("R10 alias of 0x0400 untouched", v, 8'h5A);
    getByte(16'h03FF, v);
    check("R10 alias of 0xFFFF untouched", v, 8'hC3);

    // R4: read keeps pointer and output holds
    getByte(16'h0123, v);
    rdPort(2'd3, v);
    check("R4 second read same pointer", v, 8'h77);
    repeat (3) @(negedge clk);
    check("R4 output holds", portRdata, 8'h77);

    // R1: high byte replace keeps low byte
    setIdx(16'h0023);
    wrPort(2'd1, 8'h01);
    rdPort(2'd3, v);
    check("R1 high byte replace", v, 8'h77);
    wrPort(2'd0, 8'hFF);
    wrPort(2'd1, 8'h03);
    wrPort(2'd0, 8'hFF);
    rdPort(2'd3, v);
    check("R1 low byte replace", v, 8'hC3);

    // R3: data write clears pointer
    putByte(16'h0040, 8'h45);
    rdPort(2'd3, v);
    check("R3 pointer zero after write", v, 8'h5A);
    wrPort(2'd3, 8'h66);
    getByte(16'h0000, v);
    check("R3 second write lands at 0", v, 8'h66);
    getByte(16'h0040, v);
    check("R2 byte at 0x40", v, 8'h45);

    // R5: other offsets read all ones
    setIdx(16'h0001);
    rdPort(2'd0, v); check("R5 offset 0", v, 8'hFF);
    rdPort(2'd1, v); check("R5 offset 1", v, 8'hFF);
    rdPort(2'd2, v); check("R5 offset 2", v, 8'hFF);

    // R6: offset 2 writes ignored
    wrPort(2'd2, 8'hEE);
    rdPort(2'd3, v);
    check("R6 offset 2 write ignored", v, 8'hA5);

    // R7 / R9: lock 0
    flipLock(1'b0);
    getByte(16'h0020, v);
    check("R7 locked read", v, 8'hFF);
    putByte(16'h0020, 8'h55);
    getByte(16'h003F, v);
    check("R9 lock 1 untouched", v, 8'h33);
    getByte(16'h001F, v);
    check("R7 below window open", v, 8'h11);
    flipLock(1'b0);
    getByte(16'h0020, v);
    check("R7/R9 unlock, write was dropped", v, 8'h22);

    // R8: lock 1
    putByte(16'h002F, 8'h2F);
    flipLock(1'b1);
    getByte(16'h003F, v);
    check("R8 locked read", v, 8'hFF);
    getByte(16'h002F, v);
    check("R8 window 0 open", v, 8'h2F);
    putByte(16'h003F, 8'hAB);
    getByte(16'h0040, v);
    check("R8 above window open", v, 8'h45);
    flipLock(1'b1);
    getByte(16'h003F, v);
    check("R8 unlock, write was dropped", v, 8'h33);

    // R11: reset clears pointer and locks, memory survives
    flipLock(1'b0);
    flipLock(1'b1);
    setIdx(16'h0123);
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    check("R11 read data after second reset", portRdata, 8'hFF);
    rdPort(2'd3, v);
    check("R11 pointer cleared, memory kept", v, 8'h66);
    getByte(16'h0020, v);
    check("R11 lock 0 cleared", v, 8'h22);
    getByte(16'h003F, v);
    check("R11 lock 1 cleared", v, 8'h33);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule